// File: doc/BRIEF.md
# Pre/Post-Trigger Acquisition Memory Controller

This block generates the write address and write enable for an external sample memory that takes the output of a converter. It runs in one of two capture modes. In post-trigger mode it waits for an event trigger once armed, then writes every valid sample until the memory is full. In pre-trigger mode it writes from the moment it is armed. The memory acts as a ring, so it always holds the newest samples. When the trigger arrives, the block writes a programmed number of further samples and then stops. That number is given in blocks of 16 words.

Software arms the block with a mode and a block count. It can repeat the last setup with a rearm, end a capture early with a forced end-of-record, or return everything to the cleared state. The outputs give the state, an end-of-record flag, a saturating count of stored samples, and a flag that shows every memory location now holds data from the current capture. The memory depth is 2^ADDR_W words.

Top module: `acq_mem_ctrl`

## Requirements
- R1: One cycle after `arm` is asserted, `mem_addr` is 0, `eor` is 0, `valid_cnt` is 0, `wrapped` is 0 and `state` is armed-waiting. `mode_in` (0 = post-trigger, 1 = pre-trigger) and `post_blocks_in` are captured.
- R2: `state` encodes 2'b00 idle, 2'b01 armed-waiting, 2'b10 acquiring and 2'b11 done. After reset it is idle, with `mem_addr`, `eor`, `valid_cnt`, `wrapped` and `mem_we` all 0.
- R3: In post-trigger mode, no sample is written while the block is armed-waiting. A trigger moves it to acquiring on the next cycle. From then on, each `smp_vld` raises `mem_we` in the same cycle at the current `mem_addr`, and the address advances by one. After the write to address DEPTH-1, the block goes to done with `eor` set.
- R4: In pre-trigger mode, every `smp_vld` from the cycle after the arm onward is written. The address wraps from DEPTH-1 to 0, so only the newest DEPTH samples are kept.
- R5: In pre-trigger mode, a sample that arrives in the same cycle as the trigger still counts as pre-trigger data. After it, exactly 16 × `post_blocks_in` samples are written, then the state goes to done with `eor` set. With a count of 0, the trigger leads straight to done with no further writes.
- R6: `valid_cnt` rises by one on each write and saturates at DEPTH. `wrapped` is set by a write to address DEPTH-1 and stays set until the next arm, rearm or clear.
- R7: `force_eor` puts the block in done with `eor` set on the next cycle. It takes priority over a trigger or sample in the same cycle, and that sample is not written.
- R8: A trigger has no effect while the block is idle or done. In acquiring, only the first trigger after an arm counts, so a second trigger does not restart the post-trigger count. No write occurs in idle or done.
- R9: `rearm` acts like `arm` but reuses the mode and block count captured by the last `arm`.
- R10: `clr` overrides every other input. It returns the block to idle with all state cleared, and sets the stored mode to post-trigger and the stored count to 0, so a following `rearm` runs in post-trigger mode.
- R11: A sample in the same cycle as `arm`, `rearm` or `clr` is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Clear to idle and default parameters |
| arm | input | 1 | Arm with `mode_in` and `post_blocks_in` |
| rearm | input | 1 | Arm with the stored parameters |
| mode_in | input | 1 | 0 = post-trigger, 1 = pre-trigger |
| post_blocks_in | input | BLK_W | Post-trigger length in 16-word blocks |
| trig | input | 1 | Event trigger |
| smp_vld | input | 1 | A converted sample is ready this cycle |
| force_eor | input | 1 | End the record immediately |
| mem_addr | output | ADDR_W | Write address of the sample memory |
| mem_we | output | 1 | Write enable of the sample memory |
| eor | output | 1 | End-of-record flag |
| state | output | 2 | Operating state |
| valid_cnt | output | ADDR_W+1 | Stored-sample count, saturating at DEPTH |
| wrapped | output | 1 | Every location holds new data |

## Verification
The bench runs the pre-trigger ring well past one wrap. It then fires the trigger together with a sample. If the design counted that sample as post-trigger data, it would stop one write early. A second trigger mid-acquisition catches a design that reloads the counter, because that design would write past the expected end. A forced end-of-record coincides with a sample and a trigger, so a design that writes that sample or enters acquiring produces a stray write. A clear followed by a rearm shows whether stale pre-trigger parameters survive; a design with stale parameters would write while still waiting.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_ACQ  = 2'b10,
    ST_DONE = 2'b11
  } acq_state_e;

  localparam logic MODE_POST = 1'b0;
  localparam logic MODE_PRE  = 1'b1;
endpackage

// File: rtl/acq_post_ctr.sv
module acq_post_ctr #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_en;

  assign rem_en = load | dec;

  always_comb begin
    rem_d = rem_q;
    if (load)      rem_d = load_val;
    else if (dec)  rem_d = rem_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign last = (rem_q == CNT_W'(1));

  AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> rem_q != '0);  // R5
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> rem_q == $past(rem_q) - CNT_W'(1));  // R5
endmodule

// File: rtl/acq_addr_gen.sv
module acq_addr_gen #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0]   vcnt,
  output logic              wrap,
  output logic              at_end
);
  localparam int            DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(DEPTH);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W:0]   vcnt_q, vcnt_d;
  logic              wrap_q, wrap_d;
  logic              upd_en;

  assign upd_en = restart | we;
  assign at_end = (addr_q == '1);

  always_comb begin
    addr_d = addr_q;
    vcnt_d = vcnt_q;
    wrap_d = wrap_q;
    if (restart) begin
      addr_d = '0;
      vcnt_d = '0;
      wrap_d = 1'b0;
    end else if (we) begin
      addr_d = addr_q + ADDR_W'(1);
      if (vcnt_q != FULL) vcnt_d = vcnt_q + (ADDR_W+1)'(1);
      if (at_end)         wrap_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vcnt_q <= '0;
      wrap_q <= 1'b0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      vcnt_q <= vcnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign addr = addr_q;
  assign vcnt = vcnt_q;
  assign wrap = wrap_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !restart) |=> addr_q == $past(addr_q) + ADDR_W'(1));  // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (addr_q == '0) && (vcnt_q == '0) && !wrap_q);  // R1
  AST_VCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt_q <= FULL);  // R6
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !restart) |=> wrap_q);  // R6
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
#(
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             arm,
  input  logic             rearm,
  input  logic             mode_in,
  input  logic [BLK_W-1:0] blocks_in,
  input  logic             trig,
  input  logic             force_eor,
  input  logic             smp_vld,
  input  logic             at_end,
  input  logic             post_last,
  output acq_state_e       st,
  output logic             eor,
  output logic             mode,
  output logic [BLK_W-1:0] blocks,
  output logic             wr_en,
  output logic             restart,
  output logic             cnt_load,
  output logic             cnt_dec
);
  acq_state_e       st_q, st_d;
  logic             eor_q, eor_d;
  logic             mode_q, mode_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             storing, end_hit, cfg_en;

  assign restart  = clr | arm | rearm;
  assign storing  = (st_q == ST_ACQ) || (st_q == ST_WAIT && mode_q == MODE_PRE);
  assign wr_en    = smp_vld & storing & ~restart & ~force_eor;
  assign cnt_load = (st_q == ST_WAIT) & trig & ~restart & ~force_eor;
  assign cnt_dec  = wr_en & (st_q == ST_ACQ) & (mode_q == MODE_PRE);
  assign end_hit  = (mode_q == MODE_PRE) ? post_last : at_end;
  assign cfg_en   = clr | arm;

  always_comb begin
    st_d   = st_q;
    eor_d  = eor_q;
    mode_d = mode_q;
    blk_d  = blk_q;
    if (clr) begin
      st_d   = ST_IDLE;
      eor_d  = 1'b0;
      mode_d = MODE_POST;
      blk_d  = '0;
    end else if (arm) begin
      st_d   = ST_WAIT;
      eor_d  = 1'b0;
      mode_d = mode_in;
      blk_d  = blocks_in;
    end else if (rearm) begin
      st_d  = ST_WAIT;
      eor_d = 1'b0;
    end else if (force_eor) begin
      st_d  = ST_DONE;
      eor_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_WAIT: if (trig) begin
          if (mode_q == MODE_PRE && blk_q == '0) begin
            st_d  = ST_DONE;
            eor_d = 1'b1;
          end else begin
            st_d = ST_ACQ;
          end
        end
        ST_ACQ: if (wr_en && end_hit) begin
          st_d  = ST_DONE;
          eor_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      eor_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      eor_q <= eor_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_POST;
      blk_q  <= '0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
      blk_q  <= blk_d;
    end
  end

  assign st     = st_q;
  assign eor    = eor_q;
  assign mode   = mode_q;
  assign blocks = blk_q;

  AST_ARM_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !clr) |=> (st_q == ST_WAIT) && !eor_q);  // R1
  AST_FORCE_EOR: assert property (@(posedge clk) disable iff (!rst_n)
    (force_eor && !restart) |=> (st_q == ST_DONE) && eor_q);  // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !restart && !force_eor) |=> st_q == ST_IDLE);  // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && !restart) |=> st_q == ST_DONE);  // R8
  AST_CLR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st_q == ST_IDLE) && (mode_q == MODE_POST) && (blk_q == '0) && !eor_q);  // R10
  AST_REARM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !clr && !arm) |=> $stable(mode_q) && $stable(blk_q));  // R9
endmodule

// File: rtl/acq_mem_ctrl.sv
module acq_mem_ctrl
  import acq_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BLK_W   = 16,
  parameter int BLKSZ_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              arm,
  input  logic              rearm,
  input  logic              mode_in,
  input  logic [BLK_W-1:0]  post_blocks_in,
  input  logic              trig,
  input  logic              smp_vld,
  input  logic              force_eor,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              eor,
  output logic [1:0]        state,
  output logic [ADDR_W:0]   valid_cnt,
  output logic              wrapped
);
  localparam int CNT_W = BLK_W + BLKSZ_W;

  acq_state_e       st;
  logic             mode_q;
  logic [BLK_W-1:0] blk_q;
  logic             wr_en, restart, cnt_load, cnt_dec, at_end, post_last;
  logic [CNT_W-1:0] load_val;

  assign load_val = {blk_q, {BLKSZ_W{1'b0}}};

  acq_fsm #(.BLK_W(BLK_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .arm       (arm),
    .rearm     (rearm),
    .mode_in   (mode_in),
    .blocks_in (post_blocks_in),
    .trig      (trig),
    .force_eor (force_eor),
    .smp_vld   (smp_vld),
    .at_end    (at_end),
    .post_last (post_last),
    .st        (st),
    .eor       (eor),
    .mode      (mode_q),
    .blocks    (blk_q),
    .wr_en     (wr_en),
    .restart   (restart),
    .cnt_load  (cnt_load),
    .cnt_dec   (cnt_dec)
  );

  acq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .we      (wr_en),
    .addr    (mem_addr),
    .vcnt    (valid_cnt),
    .wrap    (wrapped),
    .at_end  (at_end)
  );

  acq_post_ctr #(.CNT_W(CNT_W)) u_post (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (load_val),
    .dec      (cnt_dec),
    .last     (post_last)
  );

  assign mem_we = wr_en;
  assign state  = st;

  AST_NO_WE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE || st == ST_IDLE) |-> !mem_we);  // R8
  AST_POST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && mode_q == MODE_POST) |-> !mem_we);  // R3
  AST_RESTART_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || arm || rearm) |-> !mem_we);  // R11
  AST_EOR_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    eor |-> st == ST_DONE);  // R7
endmodule

// File: tb/sim_acq_mem_ctrl.sv
module sim_acq_mem_ctrl;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clr = 1'b0, arm = 1'b0, rearm = 1'b0, mode_in = 1'b0;
  logic [15:0]       post_blocks_in = '0;
  logic              trig = 1'b0, smp_vld = 1'b0, force_eor = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we, eor, wrapped;
  logic [1:0]        state;
  logic [ADDR_W:0]   valid_cnt;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int smp_data = 0;
  int mem [DEPTH];
  string cur_req = "R2";

  always #(CLK_P/2) clk = ~clk;

  acq_mem_ctrl #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .arm(arm), .rearm(rearm),
    .mode_in(mode_in), .post_blocks_in(post_blocks_in), .trig(trig),
    .smp_vld(smp_vld), .force_eor(force_eor), .mem_addr(mem_addr),
    .mem_we(mem_we), .eor(eor), .state(state), .valid_cnt(valid_cnt),
    .wrapped(wrapped)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // monitor: memory model plus scoreboard of expected write addresses
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      mem[mem_addr] = smp_data;
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_req, " stray write"}, int'(mem_addr), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk({cur_req, " write addr"}, int'(mem_addr), e);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    clr = 0; arm = 0; rearm = 0; trig = 0; force_eor = 0;
  endtask

  task automatic push_range(input int first, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back((first + i) % DEPTH);
  endtask

  task automatic samples(input int n);
    for (int i = 0; i < n; i++) begin
      smp_vld = 1; smp_data++;
      step();
    end
    smp_vld = 0;
  endtask

  task automatic drained(input string req);
    chk({req, " pending writes"}, exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int trig_data;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R2 reset state
    chk("R2 state", state, 0); chk("R2 addr", mem_addr, 0); chk("R2 eor", eor, 0);
    chk("R2 vcnt", valid_cnt, 0); chk("R2 wrapped", wrapped, 0); chk("R2 we", mem_we, 0);

    // R8 trigger and samples in idle ignored
    cur_req = "R8";
    trig = 1; step();
    chk("R8 idle trig", state, 0);
    samples(2);
    chk("R8 idle addr", mem_addr, 0);

    // R3 post-trigger mode, arm with coincident sample (R11)
    cur_req = "R11";
    mode_in = 0; post_blocks_in = 5; arm = 1; smp_vld = 1; step(); smp_vld = 0;
    chk("R1 state", state, 1); chk("R11 addr", mem_addr, 0);
    cur_req = "R3";
    samples(3);
    chk("R3 wait no write", mem_addr, 0);
    trig = 1; step();
    chk("R3 acq", state, 2);
    push_range(0, DEPTH);
    samples(DEPTH);
    chk("R3 done", state, 3); chk("R3 eor", eor, 1);
    chk("R6 vcnt full", valid_cnt, DEPTH); chk("R6 wrapped", wrapped, 1);
    drained("R3");
    cur_req = "R8";
    trig = 1; step();
    chk("R8 done trig", state, 3);
    samples(2);
    drained("R8");

    // R4/R5 pre-trigger mode
    cur_req = "R4";
    mode_in = 1; post_blocks_in = 1; arm = 1; step();
    chk("R1 addr", mem_addr, 0); chk("R1 eor", eor, 0); chk("R1 vcnt", valid_cnt, 0);
    chk("R1 wrapped", wrapped, 0);
    push_range(0, 100);
    samples(100);
    chk("R4 waiting", state, 1); chk("R4 addr wrap", mem_addr, 100 % DEPTH);
    chk("R6 vcnt sat", valid_cnt, DEPTH); chk("R6 wrapped", wrapped, 1);
    drained("R4");
    cur_req = "R5";
    push_range(36, 17);
    trig = 1; smp_vld = 1; smp_data++; trig_data = smp_data; step(); smp_vld = 0;
    chk("R5 acq", state, 2);
    chk("R5 trig sample stored", mem[36], trig_data);
    samples(4);
    cur_req = "R8";
    trig = 1; smp_vld = 1; smp_data++; step(); smp_vld = 0;
    chk("R8 retrig no restart", state, 2);
    cur_req = "R5";
    samples(11);
    chk("R5 done", state, 3); chk("R5 eor", eor, 1);
    chk("R5 addr", mem_addr, 53);
    samples(4);
    drained("R5");

    // R9 rearm reuses pre mode, R7 forced end of record
    cur_req = "R9";
    rearm = 1; step();
    chk("R9 state", state, 1); chk("R9 addr", mem_addr, 0); chk("R9 eor", eor, 0);
    chk("R9 vcnt", valid_cnt, 0); chk("R9 wrapped", wrapped, 0);
    push_range(0, 10);
    samples(10);
    chk("R9 pre writes", valid_cnt, 10); chk("R6 not wrapped", wrapped, 0);
    drained("R9");
    cur_req = "R7";
    force_eor = 1; trig = 1; smp_vld = 1; step(); smp_vld = 0;
    chk("R7 state", state, 3); chk("R7 eor", eor, 1); chk("R7 vcnt", valid_cnt, 10);

    // R5 zero post count
    cur_req = "R5";
    mode_in = 1; post_blocks_in = 0; arm = 1; step();
    push_range(0, 3);
    samples(3);
    trig = 1; step();
    chk("R5 zero count done", state, 3); chk("R5 zero eor", eor, 1);
    chk("R5 zero addr", mem_addr, 3);
    drained("R5");

    // R10 clear overrides, defaults to post mode
    cur_req = "R10";
    mode_in = 1; post_blocks_in = 2; arm = 1; step();
    push_range(0, 5);
    samples(5);
    clr = 1; smp_vld = 1; step(); smp_vld = 0;
    chk("R10 state", state, 0); chk("R10 addr", mem_addr, 0);
    chk("R10 vcnt", valid_cnt, 0); chk("R10 eor", eor, 0);
    rearm = 1; step();
    chk("R10 rearm wait", state, 1);
    samples(3);
    chk("R10 post mode no write", mem_addr, 0);
    trig = 1; step();
    chk("R10 acq", state, 2);
    push_range(0, 2);
    samples(2);
    force_eor = 1; step();
    chk("R7 force in acq", state, 3);
    drained("R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule